// File: doc/BRIEF.md
# Tri-Level Strap Configuration Sampler

This block reads seven board-level configuration straps once, after every reset, and resolves each one to one of three levels: tied low, tied high or left open. It has no comparator for a third voltage level. Instead it alternates a weak pull-up and a weak pull-down on every pad for a set number of rounds, and it watches the synchronised pad value during a read window at the end of each phase. A pad that reads the same value on every read is tied to that level. A pad whose reads change at any point, whether because it follows the weak pulls or because it is unstable within one window, is taken to be open.

When the rounds are finished, the weak pulls are released and every open pad is driven strongly low so that it cannot drift. The classified levels are then decoded into the chip's operating settings: the configuration source (strap or serial port), the input-buffer state, the speed class, the decimation filter, the oversampling ratio, the output-lane arrangement and the output frame format. A valid flag then rises and stays high. Later changes on the pads have no effect until the next reset.

Top module: `strap_sampler`

## Requirements
- R1: While reset is held, and until `cfg_valid` rises, `cfg_valid` is 0, `pad_oe` is 0, and every decoded output reads 0.
- R2: During sampling, the weak pulls are either all up or all down, and never both on one pad. Each round has a pull-up phase followed by a pull-down phase. Each phase lasts SETTLE_CYCLES + READ_CYCLES cycles.
- R3: A pad that reads the same value on every read is classified as that level. A pad whose reads differ at any point is classified as open. This covers a pad that tracks the pulls and a pad that toggles inside one read window.
- R4: With the reset synchronizer included, `cfg_valid` rises on the (NUM_TOGGLES·2·(SETTLE_CYCLES+READ_CYCLES)+2)-th rising clock edge after `rst_n` is released. It stays high until the next reset. From that point both pull enables stay 0.
- R5: Once `cfg_valid` is high, `pad_oe` has a 1 exactly on the pads classified as open, and `pad_do` is 0 on every pad.
- R6: After `cfg_valid` rises, changes on `pad_in` do not alter any decoded output or `pad_oe` until reset.
- R7: Pad 0 selects the configuration source. Low gives strap mode with `input_buf_en`=1. Open gives strap mode with `input_buf_en`=0. High gives `serial_mode`=1.
- R8: In strap mode, pad 1 sets `speed_mode`: low→0 (low speed), open→1 (mid speed), high→2 (max speed).
- R9: In strap mode, pad 2 sets `filter_sel`: low→0 (wideband), high→1 (fourth-order sinc), open→2 (fourth-order sinc followed by first-order sinc).
- R10: In strap mode, pads 3 (high digit) and 4 (low digit) form a base-3 index, with digit values low=0, high=1, open=2, and index = 3·hi + lo. The index selects `osr_ratio`. For the wideband filter the ratios are 32,64,128,256,512,1024,2048,4096,4096. For sinc4 they are 12,16,24,32,64,128,256,1024,4096. For sinc4+sinc1 they are 64,128,320,640,1280,3200,6400,12800,32000.
- R11: In strap mode, pad 5 sets `lane_mode`: low→0 (all lanes, no time-multiplexing), high→1 (multiplexed on one lane), open→2 (multiplexed on two lanes).
- R12: In strap mode, pad 6 sets `frame_fmt`: low→0 (24 data bits), high→1 (status byte + 24 data bits), open→2 (status byte + data + CRC byte).
- R13: In strap mode, `ext_clk_sel` and `ref_hi_range` are 1. In serial mode these two flags, `input_buf_en` and all decoded fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_in | input | 7 | Pad read-back values, pad index = bit index |
| pad_pu_en | output | 7 | Weak pull-up enables |
| pad_pd_en | output | 7 | Weak pull-down enables |
| pad_oe | output | 7 | Strong driver enables (open pads after sampling) |
| pad_do | output | 7 | Strong driver values (always low) |
| cfg_valid | output | 1 | Sampling finished, settings valid |
| serial_mode | output | 1 | Configuration comes from the serial port |
| input_buf_en | output | 1 | Input buffers enabled (strap mode) |
| speed_mode | output | 2 | 0 low, 1 mid, 2 max |
| filter_sel | output | 2 | 0 wideband, 1 sinc4, 2 sinc4+sinc1 |
| osr_ratio | output | 16 | Decoded oversampling ratio |
| lane_mode | output | 2 | 0 all lanes, 1 one multiplexed lane, 2 two multiplexed lanes |
| frame_fmt | output | 2 | 0 data, 1 status+data, 2 status+data+CRC |
| ext_clk_sel | output | 1 | External clock forced (strap mode) |
| ref_hi_range | output | 1 | High reference range forced (strap mode) |

## Verification
The checks assume that a tied pad holds its level for the whole run. They also assume that an open pad reaches the level of the active weak pull within SETTLE_CYCLES minus the two synchroniser stages, and that it holds its last value once both pulls are off. The bench pad model meets these assumptions. It models an open pad as following the pull in the same cycle and keeping its value when released. It models a strongly driven pad as reading the driven value. It changes pad levels only while reset is held, except in the scenario that tests whether late changes are ignored. One pad kind toggles every clock, to cover unstable reads within a single window.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NUM_STRAPS = 7;
  localparam int IDX_SRC    = 0;
  localparam int IDX_SPEED  = 1;
  localparam int IDX_FILT   = 2;
  localparam int IDX_OSR_HI = 3;
  localparam int IDX_OSR_LO = 4;
  localparam int IDX_LANE   = 5;
  localparam int IDX_FRAME  = 6;

  typedef enum logic [1:0] {
    TRI_ZERO  = 2'd0,
    TRI_ONE   = 2'd1,
    TRI_FLOAT = 2'd2
  } tri_t;

  typedef enum logic [2:0] {
    PH_UP_SETTLE = 3'd0,
    PH_UP_READ   = 3'd1,
    PH_DN_SETTLE = 3'd2,
    PH_DN_READ   = 3'd3,
    PH_DONE      = 3'd4
  } phase_t;
endpackage

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
#(
  parameter int NUM_TOGGLES   = 4,
  parameter int SETTLE_CYCLES = 3,
  parameter int READ_CYCLES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic pull_up,
  output logic pull_dn,
  output logic sample_en,
  output logic done
);
  localparam int CMAX = (SETTLE_CYCLES > READ_CYCLES) ? SETTLE_CYCLES : READ_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TW   = $clog2(NUM_TOGGLES + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] READ_LAST   = CW'(READ_CYCLES - 1);
  localparam logic [TW-1:0] TOG_LAST    = TW'(NUM_TOGGLES - 1);

  phase_t          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [TW-1:0]   tog_q, tog_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    tog_d   = tog_q;
    case (phase_q)
      PH_UP_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          phase_d = PH_UP_READ;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_UP_READ: begin
        if (cnt_q == READ_LAST) begin
          phase_d = PH_DN_SETTLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DN_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          phase_d = PH_DN_READ;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DN_READ: begin
        if (cnt_q == READ_LAST) begin
          cnt_d = '0;
          if (tog_q == TOG_LAST) begin
            phase_d = PH_DONE;
          end else begin
            phase_d = PH_UP_SETTLE;
            tog_d   = tog_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_UP_SETTLE;
      cnt_q   <= '0;
      tog_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tog_q   <= tog_d;
    end
  end

  assign pull_up   = (phase_q == PH_UP_SETTLE) || (phase_q == PH_UP_READ);
  assign pull_dn   = (phase_q == PH_DN_SETTLE) || (phase_q == PH_DN_READ);
  assign sample_en = (phase_q == PH_UP_READ) || (phase_q == PH_DN_READ);
  assign done      = (phase_q == PH_DONE);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R2
  up_then_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up && !$past(pull_up)) |-> $past(pull_dn));

  // R2
  round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog_q <= TOG_LAST);
endmodule

// File: rtl/strap_classify.sv
module strap_classify
  import strap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic pad_s,
  output tri_t level
);
  logic seen_q, seen_d;
  logic first_q, first_d;
  logic mism_q, mism_d;

  always_comb begin
    seen_d  = seen_q;
    first_d = first_q;
    mism_d  = mism_q;
    if (!seen_q) begin
      seen_d  = 1'b1;
      first_d = pad_s;
    end else if (pad_s != first_q) begin
      mism_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      first_q <= 1'b0;
      mism_q  <= 1'b0;
    end else if (sample_en) begin
      seen_q  <= seen_d;
      first_q <= first_d;
      mism_q  <= mism_d;
    end
  end

  always_comb begin
    if (mism_q)       level = TRI_FLOAT;
    else if (first_q) level = TRI_ONE;
    else              level = TRI_ZERO;
  end

  // R3
  mism_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism_q |=> mism_q);

  // R3
  first_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(seen_q)) |-> $stable(first_q));
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic                    valid,
  input  logic [2*NUM_STRAPS-1:0] lvl_flat,
  output logic                    serial_mode,
  output logic                    input_buf_en,
  output logic [1:0]              speed_mode,
  output logic [1:0]              filter_sel,
  output logic [15:0]             osr_ratio,
  output logic [1:0]              lane_mode,
  output logic [1:0]              frame_fmt,
  output logic                    ext_clk_sel,
  output logic                    ref_hi_range
);
  function automatic logic [1:0] digit(input logic [1:0] t);
    case (t)
      TRI_ZERO: digit = 2'd0;
      TRI_ONE:  digit = 2'd1;
      default:  digit = 2'd2;
    endcase
  endfunction

  function automatic logic [15:0] osr_of(input logic [1:0] flt, input logic [3:0] idx);
    logic [15:0] r;
    r = 16'd0;
    case (flt)
      2'd1: begin
        case (idx)
          4'd0:    r = 16'd12;
          4'd1:    r = 16'd16;
          4'd2:    r = 16'd24;
          4'd3:    r = 16'd32;
          4'd4:    r = 16'd64;
          4'd5:    r = 16'd128;
          4'd6:    r = 16'd256;
          4'd7:    r = 16'd1024;
          default: r = 16'd4096;
        endcase
      end
      2'd2: begin
        case (idx)
          4'd0:    r = 16'd64;
          4'd1:    r = 16'd128;
          4'd2:    r = 16'd320;
          4'd3:    r = 16'd640;
          4'd4:    r = 16'd1280;
          4'd5:    r = 16'd3200;
          4'd6:    r = 16'd6400;
          4'd7:    r = 16'd12800;
          default: r = 16'd32000;
        endcase
      end
      default: begin
        if (idx >= 4'd7) r = 16'd4096;
        else             r = 16'd32 << idx;
      end
    endcase
    return r;
  endfunction

  logic [1:0] lv [NUM_STRAPS];
  logic       hw;
  logic [1:0] flt;
  logic [3:0] osr_idx;
  logic [1:0] spd;

  generate
    for (genvar g = 0; g < NUM_STRAPS; g++) begin : g_unpack
      assign lv[g] = lvl_flat[2*g +: 2];
    end
  endgenerate

  assign hw      = valid && (lv[IDX_SRC] != TRI_ONE);
  assign flt     = digit(lv[IDX_FILT]);
  assign osr_idx = 4'(digit(lv[IDX_OSR_HI])) * 4'd3 + 4'(digit(lv[IDX_OSR_LO]));

  always_comb begin
    case (lv[IDX_SPEED])
      TRI_ZERO: spd = 2'd0;
      TRI_ONE:  spd = 2'd2;
      default:  spd = 2'd1;
    endcase
  end

  assign serial_mode  = valid && (lv[IDX_SRC] == TRI_ONE);
  assign input_buf_en = hw && (lv[IDX_SRC] == TRI_ZERO);
  assign speed_mode   = hw ? spd : 2'd0;
  assign filter_sel   = hw ? flt : 2'd0;
  assign osr_ratio    = hw ? osr_of(flt, osr_idx) : 16'd0;
  assign lane_mode    = hw ? digit(lv[IDX_LANE]) : 2'd0;
  assign frame_fmt    = hw ? digit(lv[IDX_FRAME]) : 2'd0;
  assign ext_clk_sel  = hw;
  assign ref_hi_range = hw;
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int NUM_TOGGLES   = 4,
  parameter int SETTLE_CYCLES = 3,
  parameter int READ_CYCLES   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STRAPS-1:0]  pad_in,
  output logic [NUM_STRAPS-1:0]  pad_pu_en,
  output logic [NUM_STRAPS-1:0]  pad_pd_en,
  output logic [NUM_STRAPS-1:0]  pad_oe,
  output logic [NUM_STRAPS-1:0]  pad_do,
  output logic                   cfg_valid,
  output logic                   serial_mode,
  output logic                   input_buf_en,
  output logic [1:0]             speed_mode,
  output logic [1:0]             filter_sel,
  output logic [15:0]            osr_ratio,
  output logic [1:0]             lane_mode,
  output logic [1:0]             frame_fmt,
  output logic                   ext_clk_sel,
  output logic                   ref_hi_range
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [NUM_STRAPS-1:0] pad_m, pad_s;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pad_m <= '0;
      pad_s <= '0;
    end else begin
      pad_m <= pad_in;
      pad_s <= pad_m;
    end
  end

  logic pull_up, pull_dn, sample_en, done;

  strap_seq #(
    .NUM_TOGGLES  (NUM_TOGGLES),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .READ_CYCLES  (READ_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .pull_up  (pull_up),
    .pull_dn  (pull_dn),
    .sample_en(sample_en),
    .done     (done)
  );

  logic [2*NUM_STRAPS-1:0] lvl_flat;
  logic [NUM_STRAPS-1:0]   float_mask;

  generate
    for (genvar g = 0; g < NUM_STRAPS; g++) begin : g_pin
      tri_t lvl;
      strap_classify u_cls (
        .clk      (clk),
        .rst_n    (rst_s),
        .sample_en(sample_en),
        .pad_s    (pad_s[g]),
        .level    (lvl)
      );
      assign lvl_flat[2*g +: 2] = lvl;
      assign float_mask[g]      = (lvl == TRI_FLOAT);
    end
  endgenerate

  assign pad_pu_en = {NUM_STRAPS{pull_up}};
  assign pad_pd_en = {NUM_STRAPS{pull_dn}};
  assign pad_oe    = done ? float_mask : '0;
  assign pad_do    = '0;
  assign cfg_valid = done;

  strap_decode u_dec (
    .valid       (done),
    .lvl_flat    (lvl_flat),
    .serial_mode (serial_mode),
    .input_buf_en(input_buf_en),
    .speed_mode  (speed_mode),
    .filter_sel  (filter_sel),
    .osr_ratio   (osr_ratio),
    .lane_mode   (lane_mode),
    .frame_fmt   (frame_fmt),
    .ext_clk_sel (ext_clk_sel),
    .ref_hi_range(ref_hi_range)
  );

  // R2
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pad_pu_en & pad_pd_en) == '0);

  // R4
  pulls_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_valid |-> (pad_pu_en == '0 && pad_pd_en == '0));

  // R1
  no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !cfg_valid |-> (pad_oe == '0 && osr_ratio == 16'd0));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_valid |=> $stable({serial_mode, input_buf_en, speed_mode, filter_sel,
                           osr_ratio, lane_mode, frame_fmt, pad_oe}));

  // R13
  serial_clear_chk: assert property (@(posedge clk) disable iff (!rst_s)
    serial_mode |-> (!ext_clk_sel && !ref_hi_range && osr_ratio == 16'd0 && !input_buf_en));

  // R10
  osr_present_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_valid && !serial_mode) |-> (osr_ratio != 16'd0));
endmodule

// File: tb/tb_strap_sampler.sv
`timescale 1ns/1ps
module tb_strap_sampler;
  localparam int NT = 4;
  localparam int ST = 3;
  localparam int RD = 2;
  localparam int SEQ_LEN = NT * 2 * (ST + RD);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [6:0] pad_in, pad_pu_en, pad_pd_en, pad_oe, pad_do;
  logic       cfg_valid, serial_mode, input_buf_en, ext_clk_sel, ref_hi_range;
  logic [1:0] speed_mode, filter_sel, lane_mode, frame_fmt;
  logic [15:0] osr_ratio;

  strap_sampler #(.NUM_TOGGLES(NT), .SETTLE_CYCLES(ST), .READ_CYCLES(RD)) dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en), .pad_oe(pad_oe), .pad_do(pad_do),
    .cfg_valid(cfg_valid), .serial_mode(serial_mode), .input_buf_en(input_buf_en),
    .speed_mode(speed_mode), .filter_sel(filter_sel), .osr_ratio(osr_ratio),
    .lane_mode(lane_mode), .frame_fmt(frame_fmt),
    .ext_clk_sel(ext_clk_sel), .ref_hi_range(ref_hi_range)
  );

  // pad kinds: 0 tied low, 1 tied high, 2 open, 3 unstable (toggles every clock)
  logic [13:0] modes = '0;
  logic [6:0]  fhold = '0;
  logic        tgl   = 1'b0;

  always @(posedge clk) begin
    tgl   <= ~tgl;
    fhold <= pad_in;
  end

  always_comb begin
    for (int i = 0; i < 7; i++) begin
      if (pad_oe[i])                  pad_in[i] = pad_do[i];
      else if (modes[2*i+:2] == 2'd0) pad_in[i] = 1'b0;
      else if (modes[2*i+:2] == 2'd1) pad_in[i] = 1'b1;
      else if (modes[2*i+:2] == 2'd3) pad_in[i] = tgl;
      else if (pad_pu_en[i])          pad_in[i] = 1'b1;
      else if (pad_pd_en[i])          pad_in[i] = 1'b0;
      else                            pad_in[i] = fhold[i];
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] pk(input int p0, p1, p2, p3, p4, p5, p6);
    return {2'(p6), 2'(p5), 2'(p4), 2'(p3), 2'(p2), 2'(p1), 2'(p0)};
  endfunction

  function automatic int md(input logic [13:0] m, input int i);
    return int'(m[2*i+:2]);
  endfunction

  // base-3 digit: low 0, high 1, open or unstable 2
  function automatic int dg(input int k);
    return (k == 0) ? 0 : (k == 1) ? 1 : 2;
  endfunction

  function automatic int exp_osr(input int f, input int idx);
    int wb [9] = '{32, 64, 128, 256, 512, 1024, 2048, 4096, 4096};
    int s4 [9] = '{12, 16, 24, 32, 64, 128, 256, 1024, 4096};
    int s41[9] = '{64, 128, 320, 640, 1280, 3200, 6400, 12800, 32000};
    if (f == 0) return wb[idx];
    if (f == 1) return s4[idx];
    return s41[idx];
  endfunction

  task automatic resample(input logic [13:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    modes = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (SEQ_LEN + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_cfg(input logic [13:0] m, input string tag);
    bit ser;
    int fl;
    logic [6:0] om;
    ser = (md(m, 0) == 1);
    fl  = dg(md(m, 2));
    om  = '0;
    for (int i = 0; i < 7; i++) om[i] = (md(m, i) >= 2);
    chk(cfg_valid == 1'b1, "R4", {tag, " valid"}, cfg_valid, 1);
    chk(pad_pu_en == 0 && pad_pd_en == 0, "R4", {tag, " pulls off"}, {pad_pu_en, pad_pd_en}, 0);
    chk(pad_oe == om, "R5", {tag, " oe"}, pad_oe, om);
    chk(pad_do == 0, "R5", {tag, " do"}, pad_do, 0);
    chk(serial_mode == ser, "R7", {tag, " serial"}, serial_mode, ser);
    if (ser) begin
      chk({input_buf_en, ext_clk_sel, ref_hi_range} == 0 && osr_ratio == 0 &&
          speed_mode == 0 && filter_sel == 0 && lane_mode == 0 && frame_fmt == 0,
          "R13", {tag, " serial clear"}, osr_ratio, 0);
    end else begin
      chk(input_buf_en == (md(m, 0) == 0), "R7", {tag, " buf"}, input_buf_en, md(m, 0) == 0);
      chk(speed_mode == ((md(m, 1) == 0) ? 0 : (md(m, 1) == 1) ? 2 : 1), "R8", {tag, " speed"},
          speed_mode, (md(m, 1) == 0) ? 0 : (md(m, 1) == 1) ? 2 : 1);
      chk(filter_sel == fl, "R9", {tag, " filter"}, filter_sel, fl);
      chk(osr_ratio == exp_osr(fl, 3 * dg(md(m, 3)) + dg(md(m, 4))), "R10", {tag, " osr"},
          osr_ratio, exp_osr(fl, 3 * dg(md(m, 3)) + dg(md(m, 4))));
      chk(lane_mode == dg(md(m, 5)), "R11", {tag, " lanes"}, lane_mode, dg(md(m, 5)));
      chk(frame_fmt == dg(md(m, 6)), "R12", {tag, " frame"}, frame_fmt, dg(md(m, 6)));
      chk(ext_clk_sel && ref_hi_range, "R13", {tag, " forced clk/ref"}, {ext_clk_sel, ref_hi_range}, 3);
    end
  endtask

  task automatic t_reset_and_timing();
    @(negedge clk);
    rst_n = 1'b0;
    modes = pk(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(cfg_valid == 0 && pad_oe == 0 && osr_ratio == 0, "R1", "in reset", cfg_valid, 0);
    rst_n = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(pad_pu_en == 7'h7f || pad_pd_en == 7'h7f, "R2", "pulls during sampling", {pad_pu_en, pad_pd_en}, 7'h7f);
    chk(cfg_valid == 0 && pad_oe == 0, "R1", "mid sampling", cfg_valid, 0);
    repeat (SEQ_LEN + 1 - 8) @(posedge clk);
    @(negedge clk);
    chk(cfg_valid == 0, "R4", "one edge early", cfg_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(cfg_valid == 1, "R4", "rise edge", cfg_valid, 1);
    check_cfg(modes, "all-low");
  endtask

  task automatic t_all_open();
    logic [13:0] m;
    m = pk(2, 2, 2, 2, 2, 2, 2);
    resample(m);
    check_cfg(m, "R3 all-open");
  endtask

  task automatic t_mixed();
    logic [13:0] m;
    m = pk(0, 1, 1, 2, 1, 1, 0);
    resample(m);
    check_cfg(m, "R3 mixed");
    chk(osr_ratio == 1024, "R10", "sinc4 idx7", osr_ratio, 1024);
  endtask

  task automatic t_unstable();
    logic [13:0] m;
    m = pk(0, 3, 0, 1, 3, 0, 1);
    resample(m);
    check_cfg(m, "R3 unstable");
    chk(speed_mode == 1, "R3", "unstable -> open", speed_mode, 1);
  endtask

  task automatic t_osr_sweep();
    for (int f = 0; f < 3; f++) begin
      for (int hi = 0; hi < 3; hi++) begin
        for (int lo = 0; lo < 3; lo++) begin
          logic [13:0] m;
          int fk, hk, lk;
          fk = (f == 0) ? 0 : (f == 1) ? 1 : 2;
          hk = (hi == 2) ? 2 : hi;
          lk = (lo == 2) ? 2 : lo;
          m = pk(0, 0, fk, hk, lk, 0, 0);
          resample(m);
          chk(osr_ratio == exp_osr(f, 3 * hi + lo), "R10", "osr sweep", osr_ratio, exp_osr(f, 3 * hi + lo));
        end
      end
    end
  endtask

  task automatic t_ignore_late();
    logic [13:0] m;
    m = pk(2, 0, 1, 1, 0, 2, 1);
    resample(m);
    check_cfg(m, "pre-change");
    modes = pk(1, 1, 0, 0, 1, 1, 0);
    repeat (20) @(negedge clk);
    check_cfg(m, "R6 after change");
    resample(modes);
    check_cfg(modes, "R6 after new reset");
  endtask

  task automatic t_serial();
    logic [13:0] m;
    m = pk(1, 2, 1, 2, 2, 1, 2);
    resample(m);
    check_cfg(m, "R13 serial");
    chk(pad_oe == 7'b1011010, "R5", "serial park", pad_oe, 7'b1011010);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_and_timing();
    t_all_open();
    t_mixed();
    t_unstable();
    t_osr_sweep();
    t_ignore_late();
    t_serial();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule